// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a processor core's instruction sequencer. On every bus cycle that is not stalled, it samples a non-maskable request line and a small vector of maskable request sources. When the core signals that an instruction has finished, the block decides whether to break into an interrupt handler. If it does, it takes over the bus for seven single-cycle operations: two throw-away reads at the return address, three stack writes (return address high byte, return address low byte, status), and a little-endian two-byte vector read. It then hands the core a new PC, SP and status value in one commit pulse.

The same sequencer starts the core after a reset request. A hard reset loads power-on values. A soft reset only masks maskable interrupts and moves SP down by three. Either kind then reads the start-up vector and holds the core idle for a fixed number of cycles before the first opcode fetch.

The core owns the architectural registers. It presents their current values on `pcIn`, `spIn` and `statusIn`, and loads `pcOut`, `spOut` and `statusOut` when `archWe` pulses.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable request is latched only when `nmiLevel` is high on a sampled cycle and was low on the previous sampled cycle. A level held high does not latch again once its latch has been serviced.
- R2: A maskable request runs when any bit of `irqSrc` is set and bit 2 (I) of `statusIn` is clear. Bit 0 is the cartridge source, bit 1 the frame timer and bit 2 the sample channel. With I set, no entry is taken for a maskable request.
- R3: The entry decision at `instrDone` uses the request state sampled one cycle earlier. A request that first latches on the cycle just before `instrDone` does not cause entry on that boundary.
- R4: Entry runs one operation per cycle in this order: read at `pcIn`, read at `pcIn`, write `pcIn[15:8]`, write `pcIn[7:0]`, write status, read vector low, read vector high.
- R5: The pushed status equals `statusIn` with bit 5 forced to 1 and bit 4 forced to 0. The committed status is `statusIn` with bit 2 set, and the committed SP is `spIn` minus 3.
- R6: A pending non-maskable request wins and uses vector 0xFFFA. Otherwise the maskable vector 0xFFFE is used. The reset vector is 0xFFFC. Choosing the non-maskable vector clears its latch. The committed PC is {byte at vector+1, byte at vector}.
- R7: Each push writes address 0x0100 | SP and then decrements SP with 8-bit wrap-around.
- R8: A hard reset commits SP = 0xFD and status = 0x24, and pulses `clrRegs` with `archWe` so the core clears A, X and Y.
- R9: A soft reset commits SP = `spIn` - 3 and status = `statusIn` | 0x04, with `clrRegs` low.
- R10: After the reset vector is read, `busy` stays high for exactly BOOT_IDLE cycles, counting from the cycle of the commit pulse, and no bus operation is issued during them.
- R11: `intAck` is high for one cycle, during the vector-low read of an interrupt entry only.
- R12: While `stall` is high, the current bus operation, the SP being pushed and the sampled request state are all held.
- R13: After `rstN` is released, `busy`, `busValid`, `archWe`, `intAck` and `clrRegs` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Holds the current cycle |
| instrDone | input | 1 | Instruction boundary strobe |
| resetReq | input | 1 | Starts the reset sequence |
| resetHard | input | 1 | Reset kind: 1 hard, 0 soft |
| nmiLevel | input | 1 | Non-maskable request level |
| irqSrc | input | SRC_W | Maskable request sources |
| pcIn | input | 16 | Core PC at the boundary |
| spIn | input | 8 | Core SP |
| statusIn | input | 8 | Core status (bit 2 = I) |
| busRData | input | 8 | Read data, same cycle |
| busValid | output | 1 | Bus operation this cycle |
| busWrite | output | 1 | 1 write, 0 read |
| busAddr | output | 16 | Bus address |
| busWData | output | 8 | Write data |
| pcOut | output | 16 | PC to commit |
| spOut | output | 8 | SP to commit |
| statusOut | output | 8 | Status to commit |
| archWe | output | 1 | Commit strobe for PC, SP and status |
| clrRegs | output | 1 | Clear A, X and Y (hard reset) |
| intAck | output | 1 | Interrupt vector fetch acknowledge |
| busy | output | 1 | Sequencer owns the bus or is idling |

## Verification
The bench uses the defaults, three request sources and BOOT_IDLE = 7. With those values, each source bit is driven alone in a table row. The whole start-up idle window is short enough to count cycle by cycle. Directed cases place `instrDone` one cycle too early for a fresh request, take SP across the 0x00 to 0xFF wrap, raise both request kinds together, and stall in the middle of the pushes.

// File: rtl/irq_entry_seq_pkg.sv
package irq_entry_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;
  localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
  localparam logic [DATA_W-1:0] SP_POWER = 8'hFD;
  localparam logic [DATA_W-1:0] ST_POWER = 8'h24;
  localparam int BIT_I = 2;
  localparam int BIT_B = 4;
  localparam int BIT_U = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_DUMMY1, S_DUMMY2, S_PUSH_HI, S_PUSH_LO, S_PUSH_ST,
    S_VEC_LO, S_VEC_HI, S_RST_LO, S_RST_HI, S_BOOT
  } seq_state_t;

  typedef enum logic [1:0] { K_IRQ, K_NMI, K_RST } vec_kind_t;

  typedef struct packed {
    logic      capCtx;
    logic      dummyRd;
    logic      pushHi;
    logic      pushLo;
    logic      pushSt;
    logic      vecLo;
    logic      vecHi;
    logic      commit;
    logic      hardRst;
    vec_kind_t kind;
  } strobe_t;
endpackage

// File: rtl/irq_entry_poll.sv
module irq_entry_poll #(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             flush,
  input  logic             clrNmi,
  input  logic             nmiLevel,
  input  logic [SRC_W-1:0] irqSrc,
  input  logic             maskI,
  output logic             takeInt,
  output logic             nmiPend
);
  logic nmiPrevLvl, nmiLatch, runIrq, prevRunIrq, prevNmi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrevLvl <= 1'b0;
      nmiLatch   <= 1'b0;
      runIrq     <= 1'b0;
      prevRunIrq <= 1'b0;
      prevNmi    <= 1'b0;
    end else if (advance) begin
      if (flush) begin
        nmiPrevLvl <= 1'b0;
        nmiLatch   <= 1'b0;
        runIrq     <= 1'b0;
        prevRunIrq <= 1'b0;
        prevNmi    <= 1'b0;
      end else begin
        nmiPrevLvl <= nmiLevel;
        nmiLatch   <= (nmiLatch & ~clrNmi) | (nmiLevel & ~nmiPrevLvl);
        runIrq     <= (|irqSrc) & ~maskI;
        prevRunIrq <= runIrq;
        prevNmi    <= nmiLatch;
      end
    end
  end

  assign takeInt = prevRunIrq | prevNmi;
  assign nmiPend = nmiLatch;
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_seq_pkg::*;
#(
  parameter int BOOT_IDLE = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    stall,
  input  logic    instrDone,
  input  logic    resetReq,
  input  logic    resetHard,
  input  logic    takeInt,
  input  logic    nmiPend,
  output strobe_t stb,
  output logic    clrNmi,
  output logic    flush,
  output logic    busy,
  output logic    intAck
);
  localparam int CNT_W = $clog2(BOOT_IDLE + 1);

  seq_state_t state, nxt;
  vec_kind_t  kind, nKind;
  logic       hard, nHard;
  logic [CNT_W-1:0] cnt, nCnt;

  always_comb begin
    nxt    = state;
    nKind  = kind;
    nHard  = hard;
    nCnt   = cnt;
    clrNmi = 1'b0;
    flush  = 1'b0;
    stb    = '0;
    stb.kind    = kind;
    stb.hardRst = hard;
    stb.dummyRd = (state == S_DUMMY1) || (state == S_DUMMY2);
    stb.pushHi  = (state == S_PUSH_HI);
    stb.pushLo  = (state == S_PUSH_LO);
    stb.pushSt  = (state == S_PUSH_ST);
    stb.vecLo   = (state == S_VEC_LO) || (state == S_RST_LO);
    stb.vecHi   = (state == S_VEC_HI) || (state == S_RST_HI);
    stb.commit  = stb.vecHi;
    if (!stall) begin
      if (resetReq) begin
        nxt        = S_RST_LO;
        nKind      = K_RST;
        nHard      = resetHard;
        flush      = 1'b1;
        stb.capCtx = 1'b1;
      end else begin
        case (state)
          S_IDLE: if (instrDone && takeInt) begin
            nxt        = S_DUMMY1;
            stb.capCtx = 1'b1;
          end
          S_DUMMY1:  nxt = S_DUMMY2;
          S_DUMMY2:  nxt = S_PUSH_HI;
          S_PUSH_HI: nxt = S_PUSH_LO;
          S_PUSH_LO: nxt = S_PUSH_ST;
          S_PUSH_ST: begin
            nxt    = S_VEC_LO;
            nKind  = nmiPend ? K_NMI : K_IRQ;
            clrNmi = nmiPend;
          end
          S_VEC_LO:  nxt = S_VEC_HI;
          S_VEC_HI:  nxt = S_IDLE;
          S_RST_LO:  nxt = S_RST_HI;
          S_RST_HI: begin
            nxt  = S_BOOT;
            nCnt = '0;
          end
          S_BOOT: begin
            if (cnt == CNT_W'(BOOT_IDLE - 1)) nxt = S_IDLE;
            else nCnt = cnt + 1'b1;
          end
          default: nxt = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      kind  <= K_IRQ;
      hard  <= 1'b0;
      cnt   <= '0;
    end else begin
      state <= nxt;
      kind  <= nKind;
      hard  <= nHard;
      cnt   <= nCnt;
    end
  end

  assign busy   = (state != S_IDLE);
  assign intAck = (state == S_VEC_LO) && !stall;
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] busRData,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut,
  output logic              archWe,
  output logic              clrRegs
);
  logic [ADDR_W-1:0] pcHold, vecBase;
  logic [DATA_W-1:0] spWork, stHold, vecLoReg, stPush;

  always_comb begin
    stPush        = stHold;
    stPush[BIT_U] = 1'b1;
    stPush[BIT_B] = 1'b0;
    case (stb.kind)
      K_NMI:   vecBase = VEC_NMI;
      K_RST:   vecBase = VEC_RST;
      default: vecBase = VEC_IRQ;
    endcase
    busValid = 1'b0;
    busWrite = 1'b0;
    busAddr  = '0;
    busWData = '0;
    if (stb.dummyRd) begin
      busValid = 1'b1;
      busAddr  = pcHold;
    end else if (stb.pushHi || stb.pushLo || stb.pushSt) begin
      busValid = 1'b1;
      busWrite = 1'b1;
      busAddr  = {STACK_PAGE, spWork};
      busWData = stb.pushHi ? pcHold[ADDR_W-1:DATA_W] :
                 stb.pushLo ? pcHold[DATA_W-1:0] : stPush;
    end else if (stb.vecLo || stb.vecHi) begin
      busValid = 1'b1;
      busAddr  = stb.vecHi ? (vecBase + 1'b1) : vecBase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcHold    <= '0;
      spWork    <= '0;
      stHold    <= '0;
      vecLoReg  <= '0;
      pcOut     <= '0;
      spOut     <= '0;
      statusOut <= '0;
      archWe    <= 1'b0;
      clrRegs   <= 1'b0;
    end else begin
      archWe  <= 1'b0;
      clrRegs <= 1'b0;
      if (!stall) begin
        if (stb.capCtx) begin
          pcHold <= pcIn;
          spWork <= spIn;
          stHold <= statusIn;
        end
        if (stb.pushHi || stb.pushLo || stb.pushSt) spWork <= spWork - 1'b1;
        if (stb.vecLo) vecLoReg <= busRData;
        if (stb.commit) begin
          archWe <= 1'b1;
          pcOut  <= {busRData, vecLoReg};
          if (stb.kind == K_RST && stb.hardRst) begin
            spOut     <= SP_POWER;
            statusOut <= ST_POWER;
            clrRegs   <= 1'b1;
          end else begin
            spOut     <= (stb.kind == K_RST) ? spWork - 8'd3 : spWork;
            statusOut <= stHold | (DATA_W'(1) << BIT_I);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_seq_pkg::*;
#(
  parameter int SRC_W     = 3,
  parameter int BOOT_IDLE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              instrDone,
  input  logic              resetReq,
  input  logic              resetHard,
  input  logic              nmiLevel,
  input  logic [SRC_W-1:0]  irqSrc,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] busRData,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] statusOut,
  output logic              archWe,
  output logic              clrRegs,
  output logic              intAck,
  output logic              busy
);
  strobe_t stb;
  logic takeInt, nmiPend, clrNmi, flush;

  irq_entry_poll #(.SRC_W(SRC_W)) u_poll (
    .clk(clk), .rstN(rstN), .advance(!stall), .flush(flush), .clrNmi(clrNmi),
    .nmiLevel(nmiLevel), .irqSrc(irqSrc), .maskI(statusIn[BIT_I]),
    .takeInt(takeInt), .nmiPend(nmiPend)
  );

  irq_entry_ctrl #(.BOOT_IDLE(BOOT_IDLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .instrDone(instrDone),
    .resetReq(resetReq), .resetHard(resetHard), .takeInt(takeInt),
    .nmiPend(nmiPend), .stb(stb), .clrNmi(clrNmi), .flush(flush),
    .busy(busy), .intAck(intAck)
  );

  irq_entry_dp u_dp (
    .clk(clk), .rstN(rstN), .stall(stall), .stb(stb), .pcIn(pcIn),
    .spIn(spIn), .statusIn(statusIn), .busRData(busRData),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .pcOut(pcOut), .spOut(spOut),
    .statusOut(statusOut), .archWe(archWe), .clrRegs(clrRegs)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stall,
  input logic        busValid,
  input logic        busWrite,
  input logic [15:0] busAddr,
  input logic        archWe,
  input logic        clrRegs,
  input logic        intAck,
  input logic        busy
);
  // R7: every write lands in the stack page
  a_r7_push_page: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite |-> busAddr[15:8] == 8'h01);

  // R11: acknowledge only with a read of an interrupt vector low byte
  a_r11_ack_vec: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> busValid && !busWrite && (busAddr == 16'hFFFA || busAddr == 16'hFFFE));

  // R12: a stalled operation is presented again next cycle
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    stall && busValid |=> busValid && $stable(busAddr) && $stable(busWrite));

  // R6: a commit follows a vector high-byte read
  a_r6_commit_after_vec: assert property (@(posedge clk) disable iff (!rstN)
    archWe |-> $past(busValid) && !$past(busWrite) &&
               ($past(busAddr) == 16'hFFFB || $past(busAddr) == 16'hFFFF || $past(busAddr) == 16'hFFFD));

  // R8: register clear only with a commit, while the idle window runs
  a_r8_clear_with_commit: assert property (@(posedge clk) disable iff (!rstN)
    clrRegs |-> archWe && busy);

  // R10: no bus traffic when committing after reset vector
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    archWe && busy |-> !busValid);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .stall(stall), .busValid(busValid),
  .busWrite(busWrite), .busAddr(busAddr), .archWe(archWe),
  .clrRegs(clrRegs), .intAck(intAck), .busy(busy)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 0, instrDone = 0, resetReq = 0, resetHard = 0, nmiLevel = 0;
  logic [2:0]  irqSrc = '0;
  logic [15:0] pcIn = 16'h0000;
  logic [7:0]  spIn = 8'h00, statusIn = 8'h00, busRData;
  logic        busValid, busWrite, archWe, clrRegs, intAck, busy;
  logic [15:0] busAddr, pcOut;
  logic [7:0]  busWData, spOut, statusOut;
  int checks = 0, errs = 0;

  always #10 clk = ~clk;

  irq_entry_seq u0 (.*);

  always_comb begin
    case (busAddr)
      16'hFFFA: busRData = 8'h34;
      16'hFFFB: busRData = 8'h12;
      16'hFFFC: busRData = 8'hBC;
      16'hFFFD: busRData = 8'h9A;
      16'hFFFE: busRData = 8'h78;
      16'hFFFF: busRData = 8'h56;
      default:  busRData = 8'hEE;
    endcase
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkBus(input string req, input logic wr, input logic [15:0] a, input logic [7:0] d);
    chk(busValid === 1'b1 && busWrite === wr, req, {busValid, busWrite}, {1'b1, wr});
    chk(busAddr === a, req, busAddr, a);
    if (wr) chk(busWData === d, req, busWData, d);
  endtask

  // row: {src[2:0], status[7:0], nmi, take, isNmi}
  localparam logic [13:0] TBL [6] = '{
    {3'b001, 8'hD3, 1'b0, 1'b1, 1'b0},   // R2 cartridge source, I clear
    {3'b010, 8'hD7, 1'b0, 1'b0, 1'b0},   // R2 frame source masked by I
    {3'b100, 8'h02, 1'b0, 1'b1, 1'b0},   // R2 sample source
    {3'b000, 8'h04, 1'b1, 1'b1, 1'b1},   // R1 edge with I set
    {3'b011, 8'h00, 1'b1, 1'b1, 1'b1},   // R6 both pending, NMI wins
    {3'b000, 8'h00, 1'b0, 1'b0, 1'b0}    // no request
  };

  // entered right after the negedge that raised instrDone
  task automatic runEntry(input logic [15:0] pcv, input logic [7:0] spv, input logic [7:0] st,
                          input logic isNmi, input int stallCycles);
    logic [15:0] vec;
    logic [7:0]  pushSt;
    vec = isNmi ? 16'hFFFA : 16'hFFFE;
    pushSt = (st | 8'h20) & 8'hEF;
    @(negedge clk); instrDone = 0;
    chkBus("R4 dummy1", 1'b0, pcv, 8'h00);
    @(negedge clk); chkBus("R4 dummy2", 1'b0, pcv, 8'h00);
    @(negedge clk); chkBus("R4/R7 push hi", 1'b1, {8'h01, spv}, pcv[15:8]);
    if (stallCycles > 0) begin
      stall = 1;
      for (int i = 0; i < stallCycles; i++) begin
        @(negedge clk);
        chkBus("R12 stalled push", 1'b1, {8'h01, spv}, pcv[15:8]);
      end
      stall = 0;
    end
    @(negedge clk); chkBus("R4/R7 push lo", 1'b1, {8'h01, 8'(spv - 8'd1)}, pcv[7:0]);
    @(negedge clk); chkBus("R5/R7 push status", 1'b1, {8'h01, 8'(spv - 8'd2)}, pushSt);
    @(negedge clk); chkBus("R6 vector lo", 1'b0, vec, 8'h00);
    chk(intAck === 1'b1, "R11 ack on vector lo", intAck, 1);
    @(negedge clk); chkBus("R6 vector hi", 1'b0, vec + 16'd1, 8'h00);
    chk(intAck === 1'b0, "R11 ack single", intAck, 0);
    @(negedge clk);
    chk(archWe === 1'b1 && busy === 1'b0, "R4 commit", {archWe, busy}, 2'b10);
    chk(pcOut === (isNmi ? 16'h1234 : 16'h5678), "R6 pc", pcOut, isNmi ? 16'h1234 : 16'h5678);
    chk(spOut === 8'(spv - 8'd3), "R5/R7 sp", spOut, 8'(spv - 8'd3));
    chk(statusOut === (st | 8'h04), "R5 status I", statusOut, st | 8'h04);
  endtask

  initial begin
    #(20 * 100000);
    errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk({busy, busValid, archWe, intAck, clrRegs} === 5'b0, "R13 reset state",
        {busy, busValid, archWe, intAck, clrRegs}, 0);

    // R8 hard reset and R10 idle window
    resetReq = 1; resetHard = 1;
    @(negedge clk); resetReq = 0;
    chkBus("R8 reset vector lo", 1'b0, 16'hFFFC, 8'h00);
    @(negedge clk); chkBus("R8 reset vector hi", 1'b0, 16'hFFFD, 8'h00);
    @(negedge clk);
    chk(archWe === 1 && clrRegs === 1 && pcOut === 16'h9ABC, "R8 hard commit",
        {archWe, clrRegs, pcOut}, {2'b11, 16'h9ABC});
    chk(spOut === 8'hFD && statusOut === 8'h24, "R8 hard sp/status", {spOut, statusOut}, 16'hFD24);
    begin
      int n = 0;
      while (busy === 1'b1 && n < 20) begin
        if (busValid) chk(1'b0, "R10 bus quiet", busValid, 0);
        n++;
        @(negedge clk);
      end
      chk(n == 7, "R10 idle cycles", n, 7);
    end

    // R9 soft reset
    spIn = 8'h40; statusIn = 8'h81; resetReq = 1; resetHard = 0;
    @(negedge clk); resetReq = 0;
    @(negedge clk); @(negedge clk);
    chk(archWe === 1 && clrRegs === 0, "R9 soft commit", {archWe, clrRegs}, 2'b10);
    chk(spOut === 8'h3D && statusOut === 8'h85, "R9 soft sp/status", {spOut, statusOut}, 16'h3D85);
    repeat (8) @(negedge clk);

    // table walk
    for (int r = 0; r < 6; r++) begin
      logic [13:0] row;
      row = TBL[r];
      irqSrc = row[13:11]; statusIn = row[10:3]; nmiLevel = row[2];
      pcIn = 16'hC000 + 16'(r * 16'h0111); spIn = 8'hF0 - 8'(r);
      @(negedge clk); @(negedge clk);
      instrDone = 1;
      if (row[1]) runEntry(pcIn, spIn, statusIn, row[0], 0);
      else begin
        @(negedge clk); instrDone = 0;
        chk(busy === 0 && busValid === 0, "R2 no entry", {busy, busValid}, 0);
        chk(intAck === 0, "R11 no ack", intAck, 0);
      end
      irqSrc = 0; nmiLevel = (r == 3) ? 1'b1 : 1'b0;
      repeat (3) @(negedge clk);
      if (r == 3) begin
        // R1: level still high, latch serviced: no new entry
        instrDone = 1;
        @(negedge clk); instrDone = 0;
        chk(busy === 0, "R1 held level no retrigger", busy, 0);
        nmiLevel = 0;
        repeat (2) @(negedge clk);
      end
    end

    // R3 decision one cycle late
    statusIn = 8'h04; pcIn = 16'hA0A0; spIn = 8'h80;
    nmiLevel = 1;
    @(negedge clk); instrDone = 1;
    @(negedge clk); instrDone = 0;
    chk(busy === 0, "R3 fresh request not seen", busy, 0);
    instrDone = 1;
    runEntry(16'hA0A0, 8'h80, 8'h04, 1'b1, 0);
    nmiLevel = 0;
    repeat (3) @(negedge clk);

    // R7 wrap and R12 stall
    statusIn = 8'h00; irqSrc = 3'b001; pcIn = 16'h1357; spIn = 8'h01;
    repeat (2) @(negedge clk);
    instrDone = 1;
    runEntry(16'h1357, 8'h01, 8'h00, 1'b0, 2);
    irqSrc = 0;
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule